// File: doc/BRIEF.md
# Unlock-Sequence Flash Bank Sequencer

This block runs the erase and program flows of a byte-wide parallel flash. The flash accepts a command only after two fixed address/data unlock writes. The flash is split into two banks of `2^BANK_AW` bytes, with 8 KiB by default. A pulse on `erase_req` or `prog_req` starts a flow on the bank that `bank_sel` names.

Each flow has four stages:
1. The block issues the command writes, keeping a fixed number of idle cycles between them.
2. It waits for the flash operation to finish. It reads the bank base twice in a row and repeats until both reads return the same value.
3. It writes the reset command to the bank base.
4. It reads back the whole bank. After an erase, every byte must be blank. After programming, every byte must match the source.

The source bytes for programming come from a read port. The block drives that port with the byte index, and the data must be valid in the same cycle.

The flash bus is a simple master. The block pulses `fl_we` with an address and data. For a read it pulses `fl_re` and samples `fl_rdata` one cycle later. The offsets named below are relative to the selected bank's base address `{bank_sel, BANK_AW'0}`.

Top module: `flash_unlock_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `busy`, `done`, `fl_we` and `fl_re` are low and `err` is 0.
- R2: An erase issues these writes in this order:
  - 0xAA to offset 0x555
  - 0x55 to offset 0x2AA
  - 0x80 to 0x555
  - 0xAA to 0x555
  - 0x55 to 0x2AA
  - 0x30 to offset 0
- R3: Byte i is programmed with these writes:
  - 0xAA to 0x555
  - 0x55 to 0x2AA
  - 0xA0 to 0x555
  - `src_rdata` (read with `src_addr` = i) to offset i

  Bytes are programmed in ascending order, covering the whole bank.
- R4: Consecutive flash writes are separated by at least `GAP_CYC` cycles with `fl_we` low.
- R5: After the last command write of an operation, the block reads the bank base in pairs of back-to-back reads. It stops polling at the first pair whose two values are equal.
- R6: If `POLL_LIMIT` pairs in a row differ, the flow ends with `err` = 1 (timeout) and skips the read-back. In programming, no further bytes are written after the timeout.
- R7: Every flow, including one that timed out, writes 0xF0 to offset 0 exactly once, after its last poll.
- R8: After an erase, any bank byte that does not read 0xFF ends the flow with `err` = 2 (verify mismatch). Otherwise `err` = 0.
- R9: After programming, any bank byte that differs from the source byte at the same index ends the flow with `err` = 2. Otherwise `err` = 0.
- R10: `done` is high for exactly one cycle at the end of a flow, in the cycle where `busy` falls. `busy` is high from the cycle after a request is accepted. `err` keeps its value until the next request is accepted.
- R11: Requests that arrive while a flow is running are ignored. If `erase_req` and `prog_req` are high together, the erase is performed.
- R12: `fl_we` and `fl_re` are never high together. Every flash access stays inside the selected bank, and the other bank is left untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| erase_req | input | 1 | Start a bank erase (sampled when idle) |
| prog_req | input | 1 | Start a bank program (sampled when idle) |
| bank_sel | input | 1 | Target bank, captured at acceptance |
| busy | output | 1 | A flow is in progress |
| done | output | 1 | One-cycle pulse when a flow ends |
| err | output | 2 | 0 ok, 1 poll timeout, 2 verify mismatch |
| fl_addr | output | BANK_AW+1 | Flash byte address, top bit is the bank |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe; data returns next cycle |
| fl_rdata | input | 8 | Flash read data |
| src_addr | output | BANK_AW | Source byte index |
| src_rdata | input | 8 | Source byte at `src_addr`, same cycle |

## Verification
The failure paths are the hardest to reach, because a real flash almost always finishes and almost always verifies. The bench flash model counts down a programmable number of busy reads. While busy, it flips a status bit on each read. It can be told to stay busy forever, either from the start or after a chosen number of data writes. This exercises the poll limit in both the erase flow and the middle of a program loop. The model can also leave one cell at 0x00 after erase. That cell causes a blank-check failure, and a later program of the same bank then fails its compare, because programming can only clear bits.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_VERIFY  = 2'd2
    } err_e;

    typedef enum logic {
        OP_ERASE = 1'b0,
        OP_PROG  = 1'b1
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_GAP, S_PRD_A, S_PRD_B, S_PCMP,
        S_RST, S_RGAP, S_VRD, S_VCHK, S_FIN
    } state_e;

    localparam logic [10:0] UNLOCK_OFS_A    = 11'h555;
    localparam logic [10:0] UNLOCK_OFS_B    = 11'h2AA;
    localparam logic [7:0]  CMD_UNLOCK_A    = 8'hAA;
    localparam logic [7:0]  CMD_UNLOCK_B    = 8'h55;
    localparam logic [7:0]  CMD_ERASE_SETUP = 8'h80;
    localparam logic [7:0]  CMD_ERASE_GO    = 8'h30;
    localparam logic [7:0]  CMD_PROG        = 8'hA0;
    localparam logic [7:0]  CMD_RESET       = 8'hF0;
    localparam logic [7:0]  BLANK_BYTE      = 8'hFF;

    typedef struct packed {
        logic [10:0] ofs;
        logic [7:0]  data;
        logic        use_tgt;
        logic        use_src;
        logic        last;
    } cmd_step_t;

    // One entry of the command script for an operation.
    function automatic cmd_step_t cmd_step(input op_e op, input logic [2:0] idx);
        cmd_step_t s;
        s = '{ofs: UNLOCK_OFS_A, data: CMD_UNLOCK_A, use_tgt: 1'b0, use_src: 1'b0, last: 1'b0};
        case (idx)
            3'd0: ;
            3'd1: begin
                s.ofs  = UNLOCK_OFS_B;
                s.data = CMD_UNLOCK_B;
            end
            3'd2: s.data = (op == OP_ERASE) ? CMD_ERASE_SETUP : CMD_PROG;
            3'd3: if (op == OP_PROG) begin
                s.use_tgt = 1'b1;
                s.use_src = 1'b1;
                s.last    = 1'b1;
            end
            3'd4: begin
                s.ofs  = UNLOCK_OFS_B;
                s.data = CMD_UNLOCK_B;
            end
            default: begin
                s.ofs  = '0;
                s.data = CMD_ERASE_GO;
                s.last = 1'b1;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/flseq_gap_timer.sv
module flseq_gap_timer #(
    parameter int GAP_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ready
);
    localparam int CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (start)        cnt <= CW'(GAP_CYC - 1);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign ready = (cnt == '0);

    // R4
    gap_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (start && GAP_CYC > 1) |=> !ready);
endmodule

// File: rtl/flseq_poll_ctr.sv
module flseq_poll_ctr #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic last_try
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (bump)    cnt <= cnt + 1'b1;
    end

    assign last_try = (cnt == CW'(LIMIT - 1));

    // R6
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        bump |-> !last_try);
endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
    import flseq_pkg::*;
#(
    parameter int BANK_AW    = 13,
    parameter int GAP_CYC    = 250,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               erase_req,
    input  logic               prog_req,
    input  logic               bank_sel,
    output logic               busy,
    output logic               done,
    output logic [1:0]         err,
    output logic [BANK_AW:0]   fl_addr,
    output logic [7:0]         fl_wdata,
    output logic               fl_we,
    output logic               fl_re,
    input  logic [7:0]         fl_rdata,
    output logic [BANK_AW-1:0] src_addr,
    input  logic [7:0]         src_rdata
);
    localparam logic [BANK_AW-1:0] IDX_LAST = '1;

    state_e               state;
    op_e                  op_q;
    logic                 bank_q;
    logic [BANK_AW-1:0]   idx_q;
    logic [2:0]           step_q;
    logic [7:0]           rd_a_q;
    err_e                 err_q;
    cmd_step_t            step_now;
    logic [BANK_AW-1:0]   bank_ofs;
    logic [7:0]           expect_byte;
    logic                 gap_ready;
    logic                 poll_last;
    logic                 poll_same;
    logic                 poll_clear;
    logic                 poll_bump;

    assign step_now    = cmd_step(op_q, step_q);
    assign expect_byte = (op_q == OP_ERASE) ? BLANK_BYTE : src_rdata;
    assign poll_same   = ((rd_a_q ^ fl_rdata) == 8'h00);
    assign poll_clear  = (state == S_CMD) && step_now.last;
    assign poll_bump   = (state == S_PCMP) && !poll_same && !poll_last;

    flseq_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk(clk), .rst(rst), .start(fl_we), .ready(gap_ready)
    );

    flseq_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst(rst), .clear(poll_clear), .bump(poll_bump), .last_try(poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            op_q   <= OP_ERASE;
            bank_q <= 1'b0;
            idx_q  <= '0;
            step_q <= '0;
            rd_a_q <= '0;
            err_q  <= ERR_NONE;
        end else begin
            case (state)
                S_IDLE: if (erase_req || prog_req) begin
                    op_q   <= erase_req ? OP_ERASE : OP_PROG;
                    bank_q <= bank_sel;
                    idx_q  <= '0;
                    step_q <= '0;
                    err_q  <= ERR_NONE;
                    state  <= S_CMD;
                end
                S_CMD: state <= S_GAP;
                S_GAP: if (gap_ready) begin
                    if (step_now.last) state <= S_PRD_A;
                    else begin
                        step_q <= step_q + 3'd1;
                        state  <= S_CMD;
                    end
                end
                S_PRD_A: state <= S_PRD_B;
                S_PRD_B: begin
                    rd_a_q <= fl_rdata;
                    state  <= S_PCMP;
                end
                S_PCMP: begin
                    if (poll_same) begin
                        if (op_q == OP_PROG && idx_q != IDX_LAST) begin
                            idx_q  <= idx_q + 1'b1;
                            step_q <= '0;
                            state  <= S_CMD;
                        end else begin
                            state <= S_RST;
                        end
                    end else if (poll_last) begin
                        err_q <= ERR_TIMEOUT;
                        state <= S_RST;
                    end else begin
                        state <= S_PRD_A;
                    end
                end
                S_RST: state <= S_RGAP;
                S_RGAP: if (gap_ready) begin
                    if (err_q != ERR_NONE) state <= S_FIN;
                    else begin
                        idx_q <= '0;
                        state <= S_VRD;
                    end
                end
                S_VRD: state <= S_VCHK;
                S_VCHK: begin
                    if (fl_rdata != expect_byte) begin
                        err_q <= ERR_VERIFY;
                        state <= S_FIN;
                    end else if (idx_q == IDX_LAST) begin
                        state <= S_FIN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        state <= S_VRD;
                    end
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_wdata = '0;
        bank_ofs = '0;
        case (state)
            S_CMD: begin
                fl_we    = 1'b1;
                fl_wdata = step_now.use_src ? src_rdata : step_now.data;
                bank_ofs = step_now.use_tgt ? idx_q : BANK_AW'(step_now.ofs);
            end
            S_PRD_A, S_PRD_B: fl_re = 1'b1;
            S_RST: begin
                fl_we    = 1'b1;
                fl_wdata = CMD_RESET;
            end
            S_VRD: begin
                fl_re    = 1'b1;
                bank_ofs = idx_q;
            end
            default: ;
        endcase
    end

    assign fl_addr  = {bank_q, bank_ofs};
    assign src_addr = idx_q;
    assign busy     = (state != S_IDLE) && (state != S_FIN);
    assign done     = (state == S_FIN);
    assign err      = err_q;

    // R12
    we_re_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    // R12
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (fl_addr[BANK_AW] == $past(fl_addr[BANK_AW])));

    // R4
    write_gap_chk: assert property (@(posedge clk) disable iff (rst)
        fl_we |=> !fl_we);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && $past(state == S_IDLE)) |-> $stable(err));
endmodule

// File: tb/test_flash_unlock_seq.sv
`timescale 1ns/1ps
module test_flash_unlock_seq;
    localparam int AW     = 11;
    localparam int GAP    = 2;
    localparam int LIM    = 20;
    localparam int NB     = 1 << AW;
    localparam int E_BUSY = 6;
    localparam int P_BUSY = 2;
    localparam int WEAK   = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          erase_req = 1'b0;
    logic          prog_req = 1'b0;
    logic          bank_sel = 1'b0;
    logic          busy, done;
    logic [1:0]    err;
    logic [AW:0]   fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_we, fl_re;
    logic [7:0]    fl_rdata = 8'h00;
    logic [AW-1:0] src_addr;
    logic [7:0]    src_rdata;

    logic [7:0] src_mem [0:NB-1];
    logic [7:0] fmem    [0:2*NB-1];

    always #2 clk = ~clk;

    flash_unlock_seq #(.BANK_AW(AW), .GAP_CYC(GAP), .POLL_LIMIT(LIM)) i_flash_unlock_seq (
        .clk(clk), .rst(rst), .erase_req(erase_req), .prog_req(prog_req),
        .bank_sel(bank_sel), .busy(busy), .done(done), .err(err),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .src_addr(src_addr), .src_rdata(src_rdata)
    );

    assign src_rdata = src_mem[src_addr];

    int errors = 0, checks = 0;
    int proto_err, gap_err, bank_err, reset_writes, data_writes, erase_go, pre_reads;
    int busy_left = 0, stuck_after = -1, cyc = 0, last_wr = -100, msq = 0;
    logic stuck_all = 1'b0, weak_on = 1'b0, tog = 1'b0, exp_bank = 1'b0;

    // Flash model: unlock decoder, toggle-bit busy status, AND-only programming.
    always @(posedge clk) begin
        cyc++;
        if (fl_we) begin
            int a;
            int b;
            a = int'(fl_addr[AW-1:0]);
            b = int'(fl_addr[AW]);
            if (cyc - last_wr <= GAP) gap_err++;
            last_wr = cyc;
            if (fl_addr[AW] != exp_bank) bank_err++;
            if (fl_wdata == 8'hF0 && a == 0) begin
                reset_writes++;
                msq = 0;
            end else begin
                case (msq)
                    0: if (a == 'h555 && fl_wdata == 8'hAA) msq = 1; else begin proto_err++; msq = 0; end
                    1: if (a == 'h2AA && fl_wdata == 8'h55) msq = 2; else begin proto_err++; msq = 0; end
                    2: if (a == 'h555 && fl_wdata == 8'h80) msq = 3;
                       else if (a == 'h555 && fl_wdata == 8'hA0) msq = 6;
                       else begin proto_err++; msq = 0; end
                    3: if (a == 'h555 && fl_wdata == 8'hAA) msq = 4; else begin proto_err++; msq = 0; end
                    4: if (a == 'h2AA && fl_wdata == 8'h55) msq = 5; else begin proto_err++; msq = 0; end
                    5: begin
                        if (a == 0 && fl_wdata == 8'h30) begin
                            for (int i = 0; i < NB; i++)
                                fmem[b*NB + i] = (weak_on && i == WEAK) ? 8'h00 : 8'hFF;
                            erase_go++;
                            busy_left = E_BUSY;
                        end else proto_err++;
                        msq = 0;
                    end
                    default: begin
                        fmem[b*NB + a] = fmem[b*NB + a] & fl_wdata;
                        data_writes++;
                        busy_left = P_BUSY;
                        if (data_writes == stuck_after) stuck_all = 1'b1;
                        msq = 0;
                    end
                endcase
            end
        end
        if (fl_re) begin
            if (reset_writes == 0) pre_reads++;
            if (stuck_all || busy_left > 0) begin
                tog = ~tog;
                fl_rdata <= tog ? 8'h40 : 8'h00;
                if (!stuck_all) busy_left--;
            end else begin
                fl_rdata <= fmem[int'(fl_addr)];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic er, input logic pr, input logic bk, input bit mid_req);
        int n;
        proto_err = 0; gap_err = 0; bank_err = 0; reset_writes = 0;
        data_writes = 0; erase_go = 0; pre_reads = 0; msq = 0;
        exp_bank = bk;
        @(negedge clk);
        erase_req = er; prog_req = pr; bank_sel = bk;
        @(negedge clk);
        erase_req = 1'b0; prog_req = 1'b0; bank_sel = ~bk;
        chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
        n = 0;
        while (!done && n < 60000) begin
            @(negedge clk);
            n++;
            if (mid_req && n == 10) prog_req = 1'b1;
            if (mid_req && n == 11) prog_req = 1'b0;
        end
        chk(done == 1'b1, "R10 flow ends with done", int'(done), 1);
        chk(busy == 1'b0, "R10 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    endtask

    initial begin
        int bad;
        for (int i = 0; i < NB; i++) src_mem[i] = 8'((i * 37 + 11) & 255);
        for (int i = 0; i < 2*NB; i++) fmem[i] = 8'((i * 13 + 5) & 255);
        repeat (5) @(negedge clk);
        chk(!busy && !done && !fl_we && !fl_re && err == 2'd0, "R1 reset state", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fl_we && !fl_re && err == 2'd0, "R1 after release", int'(err), 0);

        // erase bank 0, with a program request arriving mid-flow
        run_op(1'b1, 1'b0, 1'b0, 1'b1);
        chk(err == 2'd0, "R8 clean erase", int'(err), 0);
        bad = 0;
        for (int i = 0; i < NB; i++) if (fmem[i] != 8'hFF) bad++;
        chk(bad == 0, "R2 bank blank", bad, 0);
        bad = 0;
        for (int i = NB; i < 2*NB; i++) if (fmem[i] != 8'((i * 13 + 5) & 255)) bad++;
        chk(bad == 0, "R12 other bank untouched", bad, 0);
        chk(proto_err == 0 && erase_go == 1, "R2 erase sequence", proto_err, 0);
        chk(bank_err == 0, "R12 bank of writes", bank_err, 0);
        chk(gap_err == 0, "R4 write spacing", gap_err, 0);
        chk(reset_writes == 1, "R7 one reset write", reset_writes, 1);
        chk(pre_reads == 2 * (E_BUSY / 2 + 1), "R5 poll reads erase", pre_reads, 2 * (E_BUSY / 2 + 1));
        repeat (5) @(negedge clk);
        chk(!busy && data_writes == 0, "R11 busy request ignored", data_writes, 0);

        // program bank 0
        run_op(1'b0, 1'b1, 1'b0, 1'b0);
        chk(err == 2'd0, "R9 clean program", int'(err), 0);
        bad = 0;
        for (int i = 0; i < NB; i++) if (fmem[i] != src_mem[i]) bad++;
        chk(bad == 0, "R3 bank equals source", bad, 0);
        chk(data_writes == NB && proto_err == 0, "R3 data writes", data_writes, NB);
        chk(gap_err == 0, "R4 write spacing program", gap_err, 0);
        chk(pre_reads == 4 * NB, "R5 poll reads program", pre_reads, 4 * NB);
        chk(reset_writes == 1, "R7 reset after program", reset_writes, 1);

        // erase bank 1 with one cell stuck low
        weak_on = 1'b1;
        run_op(1'b1, 1'b0, 1'b1, 1'b0);
        chk(err == 2'd2, "R8 blank check fails", int'(err), 2);
        repeat (20) @(negedge clk);
        chk(err == 2'd2, "R10 err holds", int'(err), 2);

        // program bank 1 over the bad cell
        run_op(1'b0, 1'b1, 1'b1, 1'b0);
        chk(err == 2'd2, "R9 compare fails", int'(err), 2);
        weak_on = 1'b0;

        // erase that never completes, both requests together
        stuck_all = 1'b1;
        run_op(1'b1, 1'b1, 1'b1, 1'b0);
        chk(err == 2'd1, "R6 erase timeout", int'(err), 1);
        chk(pre_reads == 2 * LIM, "R6 poll attempts", pre_reads, 2 * LIM);
        chk(erase_go == 1 && data_writes == 0, "R11 erase wins", data_writes, 0);
        chk(reset_writes == 1, "R7 reset after timeout", reset_writes, 1);
        stuck_all = 1'b0;

        // program that hangs on its fifth byte
        stuck_after = 5;
        run_op(1'b0, 1'b1, 1'b0, 1'b0);
        chk(err == 2'd1, "R6 program timeout", int'(err), 1);
        chk(data_writes == 5, "R6 program aborted", data_writes, 5);
        chk(reset_writes == 1, "R7 reset after abort", reset_writes, 1);
        stuck_all = 1'b0;
        stuck_after = -1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule